// File: doc/BRIEF.md
# PSK Carrier Phase Error Folder

This block strips phase-shift-keyed modulation from an 8-bit phase word produced by an upstream rectangular-to-polar stage, leaving a carrier phase error that is folded into an arc centred on zero. The 8-bit word spans one full turn, so all arithmetic wraps modulo one revolution.

The fold has two steps. First, the upper nibble of the phase is rotated by a programmable 4-bit two's-complement offset. One offset step is one sixteenth of a turn (22.5°). Second, the rotated word is multiplied by a power of two. The multiply is a left shift of 0 to 3 places: bits that leave the top are lost and zeros enter at the bottom. A 6-bit control register holds the offset and the shift count. The control word is chosen per modulation order. For example, QPSK uses offset 2 (45°) with a shift of 2, and BPSK uses offset 0 with a shift of 1. The folded error is registered and leaves the block one cycle later, together with a valid flag. A loop filter downstream consumes it.

Top module: `pskerr_fold`

## Requirements
- R1: After reset, out_vld and out_err are zero and the stored control word is zero. With that control word, a sample comes out equal to its input phase.
- R2: out_vld equals in_vld delayed by exactly one clock, and out_err for a sample appears in that same following cycle.
- R3: The rotation adds control bits [3:0], as a nibble, to in_phase[7:4] modulo 16. The carry out of that addition is dropped, and in_phase[3:0] passes through unchanged.
- R4: The rotated word is shifted left by control bits [5:4] (0 to 3 places). Bits above bit 7 are discarded and the vacated low bits are zero.
- R5: A control write (cfg_wr high) updates the register at the clock edge. A sample presented in the same cycle as the write uses the previous control word, and samples from the next cycle onward use the new one.
- R6: While in_vld is low, out_err keeps its last value and out_vld is low.
- R7: With control word 0x22 (offset 2, shift 2), the four ideal QPSK phases 0x20, 0x60, 0xA0 and 0xE0 all fold to an error of 0x00.
- R8: With control word 0x10 (offset 0, shift 1), the ideal BPSK phases 0x00 and 0x80 both fold to 0x00, and phase 0x40 folds to 0x80.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the control register |
| cfg_wdata | input | 6 | Control word: [3:0] offset nibble, [5:4] shift count |
| in_vld | input | 1 | Input phase sample is valid |
| in_phase | input | 8 | Phase word, full turn = 256 |
| out_vld | output | 1 | Folded error is valid |
| out_err | output | 8 | Folded phase error, two's complement |

## Verification
The bench sweeps every control word against every phase value. This exposes a nibble adder that lets its carry spill into a ninth bit or that corrupts the low nibble. It also exposes a shifter that rotates instead of discarding bits, or that fills from the top. A control write is placed in the same cycle as a valid sample: a design that applies the new word early would fold that sample with the wrong offset. The bench also leaves idle gaps, where a design that fails to hold its output would show a changed error or a stray valid flag.

// File: rtl/pskerr_fold.sv
module pskerr_fold #(
  parameter int PHASE_W = 8,
  parameter int OFS_W   = 4,
  parameter int SHIFT_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [OFS_W+SHIFT_W-1:0]   cfg_wdata,
  input  logic                       in_vld,
  input  logic [PHASE_W-1:0]         in_phase,
  output logic                       out_vld,
  output logic [PHASE_W-1:0]         out_err
);
  localparam int CFG_W = OFS_W + SHIFT_W;
  localparam int LOW_W = PHASE_W - OFS_W;

  logic [CFG_W-1:0]   cfg_q;
  logic [OFS_W-1:0]   ofs;
  logic [SHIFT_W-1:0] sh;
  logic [OFS_W-1:0]   top_rot;
  logic [PHASE_W-1:0] rot;
  logic [PHASE_W-1:0] fold;

  assign ofs     = cfg_q[OFS_W-1:0];
  assign sh      = cfg_q[CFG_W-1:OFS_W];
  assign top_rot = in_phase[PHASE_W-1:LOW_W] + ofs;
  assign rot     = {top_rot, in_phase[LOW_W-1:0]};
  assign fold    = rot << sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_err <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_err <= fold;
    end
  end

  p_vld_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  p_vld_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_err));
  p_cfg_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q));
  p_low_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sh == '0) |=> out_err[LOW_W-1:0] == $past(in_phase[LOW_W-1:0]));
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (out_err & ((PHASE_W'(1) << $past(sh)) - PHASE_W'(1))) == '0);
endmodule

// File: tb/pskerr_fold_bench.sv
module pskerr_fold_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic       in_vld = 1'b0;
  logic [7:0] in_phase = '0;
  logic       out_vld;
  logic [7:0] out_err;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pskerr_fold u_pskerr_fold (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .in_vld(in_vld), .in_phase(in_phase), .out_vld(out_vld), .out_err(out_err)
  );

  function automatic logic [7:0] model(input int ph, input int cw);
    int t;
    int r;
    t = ((ph >> 4) + (cw & 15)) & 15;
    r = (t << 4) | (ph & 15);
    return 8'((r << ((cw >> 4) & 3)) & 255);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int cw);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 6'(cw); in_vld = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic one(input string req, input int ph, input int cw);
    @(negedge clk);
    in_vld = 1'b1; in_phase = 8'(ph);
    @(negedge clk);
    in_vld = 1'b0;
    check(req, {7'd0, out_vld}, 8'd1);
    check(req, out_err, model(ph, cw));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 vld", {7'd0, out_vld}, 8'd0);
    check("R1 err", out_err, 8'd0);
    rst_n = 1'b1;
    one("R1 passthrough", 8'hA7, 0);

    // R3 R4 exhaustive streamed sweep; R2 latency each sample
    for (int cw = 0; cw < 64; cw++) begin
      write_cfg(cw);
      for (int ph = 0; ph < 256; ph++) begin
        @(negedge clk);
        if (ph > 0) begin
          check("R2 vld", {7'd0, out_vld}, 8'd1);
          check("R3/R4 fold", out_err, model(ph - 1, cw));
        end
        in_vld = 1'b1; in_phase = 8'(ph);
      end
      @(negedge clk);
      in_vld = 1'b0;
      check("R3/R4 fold", out_err, model(255, cw));
    end

    // R6 hold during idle
    write_cfg(6'h17);
    one("R6 setup", 8'h5C, 6'h17);
    held = out_err;
    in_phase = 8'hFF;
    repeat (3) begin
      @(negedge clk);
      check("R6 hold", out_err, held);
      check("R6 vld low", {7'd0, out_vld}, 8'd0);
    end

    // R5 write coincident with sample
    write_cfg(6'h05);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 6'h3B; in_vld = 1'b1; in_phase = 8'h4D;
    @(negedge clk);
    cfg_wr = 1'b0; in_phase = 8'h4D;
    check("R5 old cfg", out_err, model(8'h4D, 6'h05));
    @(negedge clk);
    in_vld = 1'b0;
    check("R5 new cfg", out_err, model(8'h4D, 6'h3B));

    // R7 QPSK
    write_cfg(6'h22);
    one("R7 q0", 8'h20, 6'h22); check("R7 zero", out_err, 8'h00);
    one("R7 q1", 8'h60, 6'h22); check("R7 zero", out_err, 8'h00);
    one("R7 q2", 8'hA0, 6'h22); check("R7 zero", out_err, 8'h00);
    one("R7 q3", 8'hE0, 6'h22); check("R7 zero", out_err, 8'h00);
    one("R7 err", 8'h23, 6'h22); check("R7 small", out_err, 8'h0C);

    // R8 BPSK
    write_cfg(6'h10);
    one("R8 b0", 8'h00, 6'h10); check("R8 zero", out_err, 8'h00);
    one("R8 b1", 8'h80, 6'h10); check("R8 zero", out_err, 8'h00);
    one("R8 edge", 8'h40, 6'h10); check("R8 edge", out_err, 8'h80);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule